// File: doc/BRIEF.md
# PC-Indexed Local Branch Predictor

This block keeps a table of saturating counters, one per table slot, and selects a slot from the low-order word-address bits of the program counter that is presented to it. In every cycle it gives a taken or not-taken prediction for the presented PC. The PC does not have to belong to a branch. The prediction is combinational from the table, so it is valid in the same cycle the PC is presented.

Training is strobe-driven. The update strobe does not carry an address. It always refers to the slot that was looked up in the cycle before the strobe, and the block keeps that slot number in a register. When the strobe is high, the resolved outcome moves the remembered slot's counter one step toward taken or one step toward not-taken. The counter saturates at both ends. The table depth and the counter width are parameters. By default the table has 32 slots of 2-bit counters.

Top module: `local_branch_predictor`

## Requirements
- R1: `prediction` is the most significant bit of the counter in slot `pc[IDX_W+1:2]`, where IDX_W = log2(ENTRIES). It follows `pc` in the same cycle and is never unknown after reset.
- R2: Reset puts every counter at 2^(CTR_W-1)-1, the weakly-not-taken value. After reset, every PC therefore predicts not taken (0) until a counter is trained.
- R3: When `update` is high and `taken` is high, the remembered slot's counter increases by one and stops at 2^CTR_W-1.
- R4: When `update` is high and `taken` is low, the remembered slot's counter decreases by one and stops at 0.
- R5: An update changes the slot selected by `pc` in the previous cycle, never the slot of the current `pc`. Every other slot keeps its value.
- R6: In a cycle with `update` low, no counter changes.
- R7: `pc[1:0]` and every bit above `pc[IDX_W+1]` play no part in slot selection. Two PCs that differ only in those bits share one counter.
- R8: When the slot being trained is also the slot being read, `prediction` in that cycle shows the counter value from before the update. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| pc | input | PC_W | Program counter to look up |
| update | input | 1 | Train the slot looked up in the previous cycle |
| taken | input | 1 | Resolved outcome for the update: 1 = taken, 0 = not taken |
| prediction | output | 1 | 1 = predict taken, 0 = predict not taken |

## Verification
The properties assume that `update` is never raised in the first cycle after reset is released, because no lookup has been made yet for it to refer to. The stimulus starts every training sequence at least one cycle after reset, in line with this. The saturation and slot-isolation properties only apply when a PC is held, or returns to the same slot, over consecutive cycles. Directed phases therefore hold or alternate PCs on purpose. A long random phase then mixes held and changing PCs, aliased upper and lower bits, and arbitrary update and outcome patterns.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

  typedef enum logic {
    LBP_DIR_DOWN = 1'b0,
    LBP_DIR_UP   = 1'b1
  } lbp_dir_e;

  function automatic logic [31:0] lbp_weak_nt(input int unsigned width);
    lbp_weak_nt = (32'd1 << (width - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/lbp_index_map.sv
module lbp_index_map #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int unsigned LSB = 2;

  always_comb idx = pc[LSB +: IDX_W];
endmodule

// File: rtl/lbp_sat_counter.sv
module lbp_sat_counter
  import lbp_pkg::*;
#(
  parameter int unsigned CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  lbp_dir_e         step_dir,
  output logic [CTR_W-1:0] value
);
  localparam logic [CTR_W-1:0] INIT_V = CTR_W'(lbp_weak_nt(CTR_W));
  localparam logic [CTR_W-1:0] MAX_V  = {CTR_W{1'b1}};

  logic [CTR_W-1:0] next_v;

  always_comb begin
    next_v = value;
    if (step_en) begin
      if (step_dir == LBP_DIR_UP) begin
        if (value != MAX_V) next_v = value + CTR_W'(1);
      end else begin
        if (value != '0) next_v = value - CTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= INIT_V;
    else        value <= next_v;
  end
endmodule

// File: rtl/lbp_readout.sv
module lbp_readout #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned CTR_W   = 2,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [ENTRIES-1:0][CTR_W-1:0] table_q,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic                          dir_bit
);
  logic [CTR_W-1:0] sel;

  always_comb begin
    sel     = table_q[rd_idx];
    dir_bit = sel[CTR_W-1];
  end
endmodule

// File: rtl/local_branch_predictor.sv
module local_branch_predictor
  import lbp_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned CTR_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc,
  input  logic            update,
  input  logic            taken,
  output logic            prediction
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0]              idx_now;
  logic [IDX_W-1:0]              idx_prev;
  logic [ENTRIES-1:0][CTR_W-1:0] table_q;
  lbp_dir_e                      dir;

  lbp_index_map #(.PC_W(PC_W), .IDX_W(IDX_W)) u_map (
    .pc  (pc),
    .idx (idx_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_prev <= '0;
    else        idx_prev <= idx_now;
  end

  always_comb dir = taken ? LBP_DIR_UP : LBP_DIR_DOWN;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic hit;
    always_comb hit = update && (idx_prev == IDX_W'(g));
    lbp_sat_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (hit),
      .step_dir (dir),
      .value    (table_q[g])
    );
  end

  lbp_readout #(.ENTRIES(ENTRIES), .CTR_W(CTR_W), .IDX_W(IDX_W)) u_rd (
    .table_q (table_q),
    .rd_idx  (idx_now),
    .dir_bit (prediction)
  );
endmodule

// File: rtl/lbp_checker.sv
module lbp_checker #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc,
  input logic            update,
  input logic            taken,
  input logic            prediction
);
  localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [1:0]      age;
  logic [IW-1:0]   i0, i1, i2;
  logic            upd1, tk1, pr1;

  always_comb i0 = pc[2 +: IW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0; i1 <= '0; i2 <= '0; upd1 <= 1'b0; tk1 <= 1'b0; pr1 <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      i1 <= i0; i2 <= i1; upd1 <= update; tk1 <= taken; pr1 <= prediction;
    end
  end

  AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(prediction)); // R1

  AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> !prediction); // R2

  AST_SAT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && upd1 && tk1 && pr1 && i2 == i1 && i0 == i1) |-> prediction); // R3

  AST_SAT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && upd1 && !tk1 && !pr1 && i2 == i1 && i0 == i1) |-> !prediction); // R4

  AST_OTHER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && upd1 && i2 != i1 && i0 == i1) |-> (prediction == pr1)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !upd1 && i0 == i1) |-> (prediction == pr1)); // R6
endmodule

bind local_branch_predictor lbp_checker #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_lbp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc         (pc),
  .update     (update),
  .taken      (taken),
  .prediction (prediction)
);

// File: tb/test_local_branch_predictor.sv
module test_local_branch_predictor;
  localparam int PC_W = 32;
  localparam int ENTRIES = 32;
  localparam int CTR_W = 2;
  localparam int IW = $clog2(ENTRIES);
  localparam int MAXC = (1 << CTR_W) - 1;
  localparam int INITC = (1 << (CTR_W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic update = 1'b0;
  logic taken = 1'b0;
  logic prediction;

  int compared = 0;
  int mismatched = 0;
  string req = "R2";
  int model [ENTRIES];
  int last_idx = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  local_branch_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES), .CTR_W(CTR_W)) i_local_branch_predictor (
    .clk(clk), .rst_n(rst_n), .pc(pc), .update(update), .taken(taken), .prediction(prediction)
  );

  function automatic int idx_of(logic [PC_W-1:0] p);
    return int'(p[2 +: IW]);
  endfunction

  // Reference model: table of integers, remembered slot
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ENTRIES; k++) model[k] = INITC;
      last_idx = 0;
    end else begin
      if (update) begin
        if (taken && model[last_idx] < MAXC) model[last_idx]++;
        else if (!taken && model[last_idx] > 0) model[last_idx]--;
      end
      last_idx = idx_of(pc);
    end
  end

  // Compare on every falling edge while out of reset (R1, R8 every cycle)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic logic exp = model[idx_of(pc)][CTR_W-1];
      compared++;
      if (prediction !== exp) begin
        mismatched++;
        $display("FAIL %s pc=%h actual=%b expected=%b", req, pc, prediction, exp);
      end
    end
  end

  task automatic step(input logic [PC_W-1:0] p, input logic u, input logic t);
    pc = p; update = u; taken = t;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) @(negedge clk);
    rst_n = 1'b1;
    // R2: every slot weakly not taken after reset
    req = "R2";
    for (int k = 0; k < ENTRIES; k++) step(PC_W'(k * 4), 1'b0, 1'b0);
    // R3: train one slot up to saturation
    req = "R3";
    step(32'h0000_0014, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) step(32'h0000_0014, 1'b1, 1'b1);
    // R4: train down to zero and beyond
    req = "R4";
    for (int k = 0; k < 6; k++) step(32'h0000_0014, 1'b1, 1'b0);
    // R5: update lands on previous cycle's slot only
    req = "R5";
    for (int k = 0; k < 4; k++) begin
      step(32'h0000_0040, 1'b0, 1'b0);
      step(32'h0000_0044, 1'b1, 1'b1);
    end
    step(32'h0000_0044, 1'b0, 1'b0);
    // R6: idle cycles, no change
    req = "R6";
    for (int k = 0; k < 8; k++) step(PC_W'(k * 8), 1'b0, 1'b1);
    // R7: aliasing through ignored bits
    req = "R7";
    step(32'h0000_0023, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) step(32'hABC0_0020 | PC_W'(k), 1'b1, 1'b1);
    step(32'h1234_5622, 1'b0, 1'b0);
    // R8: read and write of one slot in the same cycle
    req = "R8";
    step(32'h0000_0070, 1'b0, 1'b0);
    step(32'h0000_0070, 1'b1, 1'b1);
    step(32'h0000_0070, 1'b1, 1'b1);
    step(32'h0000_0070, 1'b0, 1'b0);
    // R1: random mix
    req = "R1";
    for (int k = 0; k < 3000; k++) begin
      automatic logic [PC_W-1:0] p = ($urandom_range(0, 3) == 0) ? pc : $urandom;
      step(p, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule